// File: doc/BRIEF.md
# Chip-Select Sequencer

This block owns the chip-select lines of a serial peripheral port and places each frame of the shift engine inside a correctly timed select window. Software picks one line by index. Software also gives every line an idle level, so active-low and active-high targets can share the port. The assertion mode decides what happens between frames. In auto mode the line drops after every frame. In hold mode the line stays asserted across frames. In off mode the hardware never drives a line. These modes let software keep one device selected across a multi-frame command, or drive the selects itself.

Four programmable delays shape the window. All four count pulses of `sck_tick_i`, which the clock divider raises once per serial clock period. They are: the lead from select assertion to the first serial edge, the lag from the last edge to deassertion, the minimum time a line rests deasserted, and the gap between frames while the line is held. The shift engine asks for a frame with a request. It shifts while the grant is high and ends the frame with a one-cycle done pulse. The idle-level register only stores as many bits as there are lines, so software can write all ones and read back the line count.

Top module: `cs_seq`

## Requirements
- R1: After reset the registers read back: index 0 (address 0), idle levels all ones (address 1), mode 0 (address 2), delay word 0x00010001 (address 3), delay word 0x00000001 (address 4). All lines sit at their idle level and the grant is low.
- R2: The idle-level register (address 1) stores one bit per implemented line, with bit i belonging to line i. Writing all ones and reading back returns ones only in the low NUM_CS bit positions.
- R3: A line that is not selected always shows its idle bit. While asserted, the selected line shows the inverse of its idle bit. An index at or above NUM_CS asserts no line. At most one line differs from its idle level at any time.
- R4: The lead delay sits in bits 7:0 of address 3. The grant rises max(lead,1) tick pulses after the select line is asserted, and it does not rise while no tick arrives.
- R5: The lag delay sits in bits 23:16 of address 3. Counting from the grant's fall, the select line stays asserted for max(lag,1) tick pulses. The grant falls on the clock edge that follows the done pulse.
- R6: The rest time sits in bits 7:0 of address 4. In auto mode (mode value 0), a line released after a frame stays deasserted for max(rest,1) ticks plus one cycle before a pending request asserts it again.
- R7: In hold mode (mode value 2), the line stays asserted after a frame and while no request is pending. The gap delay sits in bits 23:16 of address 4. A pending request is granted max(lag,1)+1+max(gap,1) cycles after the previous grant fell, with ticks on every cycle.
- R8: In off mode (mode value 3), no line leaves its idle level. A request is granted on the first clock edge that sees it, and the grant falls on the edge after done.
- R9: A write of the index or the mode during a frame does not change the select lines until the frame ends. The next frame uses the new values. A write that changes the index or leaves hold mode while a line is held releases that line.
- R10: The delay words read back only their two 8-bit fields, at bits 7:0 and 23:16. All other bits read zero.
- R11: Once raised, the grant stays high until the done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_waddr_i | input | 3 | Write address |
| reg_wdata_i | input | 32 | Write data |
| reg_raddr_i | input | 3 | Read address |
| reg_rdata_o | output | 32 | Read data, combinational from read address |
| sck_tick_i | input | 1 | One pulse per serial clock period; all delays count it |
| frame_req_i | input | 1 | Shift engine has a frame ready; held until grant |
| frame_gnt_o | output | 1 | Shift engine may run the frame |
| frame_done_i | input | 1 | One-cycle pulse after the last serial edge |
| cs_o | output | NUM_CS | Chip-select lines |

## Verification
The select lines, the grant and the read data each come out on a fixed cycle. A register write is visible on the read port and at the select lines one clock edge after the strobe. A request seen on an edge moves the lines at that edge. The grant then follows max(lead,1) cycles later when ticks run on every cycle. The monitor measures the distance, in clock edges, between the grant edges and the select edges at negative clock edges, and compares each distance in order against the expected value that the driver queued from the programmed delays. Direct checks sample exactly one or two edges after their stimulus: for example, the off-mode grant one cycle after the request, and the grant two cycles after ticks resume.

// File: rtl/cs_seq_pkg.sv
package cs_seq_pkg;
  localparam int MAX_CS = 32;
  localparam int ID_W   = $clog2(MAX_CS);
  localparam int AW     = 3;
  localparam int DW     = 32;
  localparam int HI_LSB = 16;

  localparam logic [AW-1:0] A_ID   = 3'd0;
  localparam logic [AW-1:0] A_DEF  = 3'd1;
  localparam logic [AW-1:0] A_MODE = 3'd2;
  localparam logic [AW-1:0] A_DLY0 = 3'd3;
  localparam logic [AW-1:0] A_DLY1 = 3'd4;

  localparam logic [1:0] M_AUTO = 2'd0;
  localparam logic [1:0] M_HOLD = 2'd2;
  localparam logic [1:0] M_OFF  = 2'd3;

  typedef enum logic [2:0] {
    ST_IDLE, ST_SETUP, ST_ACTIVE, ST_TAIL, ST_REST, ST_HELD, ST_GAP
  } cs_state_e;
endpackage

// File: rtl/cs_seq_regs.sv
module cs_seq_regs
  import cs_seq_pkg::*;
#(
  parameter int NUM_CS = 4,
  parameter int DLY_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [AW-1:0]     waddr_i,
  input  logic [DW-1:0]     wdata_i,
  input  logic [AW-1:0]     raddr_i,
  output logic [DW-1:0]     rdata_o,
  output logic [ID_W-1:0]   id_o,
  output logic [NUM_CS-1:0] def_o,
  output logic [1:0]        mode_o,
  output logic [DLY_W-1:0]  lead_o,
  output logic [DLY_W-1:0]  lag_o,
  output logic [DLY_W-1:0]  rest_o,
  output logic [DLY_W-1:0]  gap_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      id_o   <= '0;
      def_o  <= '1;
      mode_o <= M_AUTO;
      lead_o <= DLY_W'(1);
      lag_o  <= DLY_W'(1);
      rest_o <= DLY_W'(1);
      gap_o  <= '0;
    end else if (we_i) begin
      case (waddr_i)
        A_ID:   id_o   <= wdata_i[ID_W-1:0];
        A_DEF:  def_o  <= wdata_i[NUM_CS-1:0];
        A_MODE: mode_o <= wdata_i[1:0];
        A_DLY0: begin
          lead_o <= wdata_i[DLY_W-1:0];
          lag_o  <= wdata_i[HI_LSB +: DLY_W];
        end
        A_DLY1: begin
          rest_o <= wdata_i[DLY_W-1:0];
          gap_o  <= wdata_i[HI_LSB +: DLY_W];
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    rdata_o = '0;
    case (raddr_i)
      A_ID:   rdata_o[ID_W-1:0]   = id_o;
      A_DEF:  rdata_o[NUM_CS-1:0] = def_o;
      A_MODE: rdata_o[1:0]        = mode_o;
      A_DLY0: begin
        rdata_o[DLY_W-1:0]         = lead_o;
        rdata_o[HI_LSB +: DLY_W]   = lag_o;
      end
      A_DLY1: begin
        rdata_o[DLY_W-1:0]         = rest_o;
        rdata_o[HI_LSB +: DLY_W]   = gap_o;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/cs_seq_timer.sv
module cs_seq_timer #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  input  logic         tick_i,
  output logic         done_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   cnt_q <= '0;
    else if (load_i)               cnt_q <= val_i;
    else if (tick_i && cnt_q != '0) cnt_q <= cnt_q - W'(1);
  end

  // last tick ends the wait in the same cycle; zero load waits one cycle
  assign done_o = (cnt_q == '0) || (cnt_q == W'(1) && tick_i);
endmodule

// File: rtl/cs_seq_ctrl.sv
module cs_seq_ctrl
  import cs_seq_pkg::*;
#(
  parameter int DLY_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [ID_W-1:0]  reg_id_i,
  input  logic [1:0]       reg_mode_i,
  input  logic [DLY_W-1:0] lead_i,
  input  logic [DLY_W-1:0] lag_i,
  input  logic [DLY_W-1:0] rest_i,
  input  logic [DLY_W-1:0] gap_i,
  input  logic             tick_i,
  input  logic             req_i,
  input  logic             done_i,
  output logic             gnt_o,
  output logic             asrt_o,
  output logic [ID_W-1:0]  act_id_o,
  output logic [1:0]       act_mode_o
);
  cs_state_e        st_q, st_d;
  logic             load;
  logic [DLY_W-1:0] load_val;
  logic             t_done;
  logic             keep_held;

  cs_seq_timer #(.W(DLY_W)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .val_i  (load_val),
    .tick_i (tick_i),
    .done_o (t_done)
  );

  assign keep_held = (reg_mode_i == M_HOLD) && (reg_id_i == act_id_o);

  always_comb begin
    st_d     = st_q;
    load     = 1'b0;
    load_val = '0;
    unique case (st_q)
      ST_IDLE:
        if (req_i) begin
          if (reg_mode_i == M_OFF) st_d = ST_ACTIVE;
          else begin
            st_d = ST_SETUP; load = 1'b1; load_val = lead_i;
          end
        end
      ST_SETUP:
        if (t_done) st_d = ST_ACTIVE;
      ST_ACTIVE:
        if (done_i) begin
          if (act_mode_o == M_OFF) st_d = ST_IDLE;
          else begin
            st_d = ST_TAIL; load = 1'b1; load_val = lag_i;
          end
        end
      ST_TAIL:
        if (t_done) begin
          if (act_mode_o == M_HOLD && keep_held) st_d = ST_HELD;
          else begin
            st_d = ST_REST; load = 1'b1; load_val = rest_i;
          end
        end
      ST_REST:
        if (t_done) st_d = ST_IDLE;
      ST_HELD:
        if (!keep_held) begin
          st_d = ST_REST; load = 1'b1; load_val = rest_i;
        end else if (req_i) begin
          st_d = ST_GAP; load = 1'b1; load_val = gap_i;
        end
      ST_GAP:
        if (t_done) st_d = ST_ACTIVE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_IDLE;
      act_id_o   <= '0;
      act_mode_o <= M_AUTO;
    end else begin
      st_q <= st_d;
      // configuration is sampled only between frames
      if (st_q == ST_IDLE) begin
        act_id_o   <= reg_id_i;
        act_mode_o <= reg_mode_i;
      end
    end
  end

  assign gnt_o  = (st_q == ST_ACTIVE);
  assign asrt_o = (act_mode_o != M_OFF) &&
                  (st_q inside {ST_SETUP, ST_ACTIVE, ST_TAIL, ST_HELD, ST_GAP});
endmodule

// File: rtl/cs_seq_drive.sv
module cs_seq_drive
  import cs_seq_pkg::*;
#(
  parameter int NUM_CS = 4
) (
  input  logic [NUM_CS-1:0] def_i,
  input  logic              asrt_i,
  input  logic [ID_W-1:0]   id_i,
  output logic [NUM_CS-1:0] cs_o
);
  for (genvar i = 0; i < NUM_CS; i++) begin : g_line
    assign cs_o[i] = def_i[i] ^ (asrt_i && (id_i == ID_W'(i)));
  end
endmodule

// File: rtl/cs_seq.sv
module cs_seq
  import cs_seq_pkg::*;
#(
  parameter int NUM_CS = 4,
  parameter int DLY_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [AW-1:0]     reg_waddr_i,
  input  logic [DW-1:0]     reg_wdata_i,
  input  logic [AW-1:0]     reg_raddr_i,
  output logic [DW-1:0]     reg_rdata_o,
  input  logic              sck_tick_i,
  input  logic              frame_req_i,
  output logic              frame_gnt_o,
  input  logic              frame_done_i,
  output logic [NUM_CS-1:0] cs_o
);
  logic [ID_W-1:0]   reg_id, act_id;
  logic [NUM_CS-1:0] def_q;
  logic [1:0]        reg_mode, act_mode;
  logic [DLY_W-1:0]  lead, lag, rest, gap;
  logic              asrt;

  cs_seq_regs #(.NUM_CS(NUM_CS), .DLY_W(DLY_W)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (reg_we_i),
    .waddr_i (reg_waddr_i),
    .wdata_i (reg_wdata_i),
    .raddr_i (reg_raddr_i),
    .rdata_o (reg_rdata_o),
    .id_o    (reg_id),
    .def_o   (def_q),
    .mode_o  (reg_mode),
    .lead_o  (lead),
    .lag_o   (lag),
    .rest_o  (rest),
    .gap_o   (gap)
  );

  cs_seq_ctrl #(.DLY_W(DLY_W)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .reg_id_i   (reg_id),
    .reg_mode_i (reg_mode),
    .lead_i     (lead),
    .lag_i      (lag),
    .rest_i     (rest),
    .gap_i      (gap),
    .tick_i     (sck_tick_i),
    .req_i      (frame_req_i),
    .done_i     (frame_done_i),
    .gnt_o      (frame_gnt_o),
    .asrt_o     (asrt),
    .act_id_o   (act_id),
    .act_mode_o (act_mode)
  );

  cs_seq_drive #(.NUM_CS(NUM_CS)) u_drive (
    .def_i  (def_q),
    .asrt_i (asrt),
    .id_i   (act_id),
    .cs_o   (cs_o)
  );
endmodule

// File: rtl/cs_seq_chk.sv
module cs_seq_chk
  import cs_seq_pkg::*;
#(
  parameter int NUM_CS = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              frame_gnt_o,
  input logic              frame_done_i,
  input logic [NUM_CS-1:0] cs_o,
  input logic [NUM_CS-1:0] def_i,
  input logic [1:0]        act_mode_i,
  input logic              reg_we_i,
  input logic [AW-1:0]     reg_waddr_i,
  input logic [AW-1:0]     reg_raddr_i,
  input logic [DW-1:0]     reg_rdata_o
);
  logic def_wr;
  assign def_wr = reg_we_i && (reg_waddr_i == A_DEF);

  p_one_line_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(cs_o ^ def_i) <= 1);

  p_off_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_mode_i == M_OFF |-> cs_o == def_i);

  p_gnt_held_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_gnt_o && !frame_done_i |=> frame_gnt_o);

  p_cs_frozen_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_gnt_o && !frame_done_i && !def_wr |=> $stable(cs_o));

  p_tail_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(frame_gnt_o) && !$past(def_wr) |-> $stable(cs_o));

  p_def_mask_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_raddr_i == A_DEF |-> (reg_rdata_o >> NUM_CS) == '0);
endmodule

bind cs_seq cs_seq_chk #(.NUM_CS(NUM_CS)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .frame_gnt_o  (frame_gnt_o),
  .frame_done_i (frame_done_i),
  .cs_o         (cs_o),
  .def_i        (def_q),
  .act_mode_i   (act_mode),
  .reg_we_i     (reg_we_i),
  .reg_waddr_i  (reg_waddr_i),
  .reg_raddr_i  (reg_raddr_i),
  .reg_rdata_o  (reg_rdata_o)
);

// File: tb/cs_seq_bench.sv
module cs_seq_bench;
  import cs_seq_pkg::*;
  localparam int NUM_CS = 4;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              we;
  logic [AW-1:0]     waddr, raddr;
  logic [DW-1:0]     wdata, rdata;
  logic              tick, req, gnt, done;
  logic [NUM_CS-1:0] cs;

  always #2 clk = ~clk;

  cs_seq #(.NUM_CS(NUM_CS), .DLY_W(8)) u_cs_seq (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .reg_we_i     (we),
    .reg_waddr_i  (waddr),
    .reg_wdata_i  (wdata),
    .reg_raddr_i  (raddr),
    .reg_rdata_o  (rdata),
    .sck_tick_i   (tick),
    .frame_req_i  (req),
    .frame_gnt_o  (gnt),
    .frame_done_i (done),
    .cs_o         (cs)
  );

  int n_run = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  typedef struct {
    int    kind;   // 0 grant rise, 1 select release, 2 select re-assert
    int    val;
    string tag;
  } item_t;
  item_t exp_q[$];

  bit                mon_en = 1'b0;
  bit                track_rise = 1'b0;
  bit                armed = 1'b0;
  logic [NUM_CS-1:0] cur_def = '1;
  logic              mon_any;
  logic              prev_any = 1'b0;
  logic              prev_gnt = 1'b0;
  int                since = 0;

  assign mon_any = (cs != cur_def);

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic push(input int kind, input int val, input string tag);
    item_t it;
    it.kind = kind; it.val = val; it.tag = tag;
    exp_q.push_back(it);
  endtask

  task automatic report(input int kind, input int val);
    item_t it;
    if (exp_q.size() == 0) begin
      chk(1'b0, "R4 unexpected timing event", longint'(kind), -1);
    end else begin
      it = exp_q.pop_front();
      chk(it.kind == kind && it.val == val, it.tag, longint'(val), longint'(it.val));
    end
  endtask

  // monitor: edge-to-edge distances between grant and select changes
  always @(negedge clk) begin
    if (mon_en) begin
      if (gnt && !prev_gnt) report(0, since + 1);
      if (!mon_any && prev_any) begin
        report(1, since + 1);
        armed = 1'b1;
      end
      if (mon_any && !prev_any && track_rise && armed) begin
        report(2, since + 1);
        armed = 1'b0;
      end
    end
    if ((mon_any != prev_any) || (!gnt && prev_gnt)) since = 0;
    else since++;
    prev_any = mon_any;
    prev_gnt = gnt;
  end

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    we = 1'b1; waddr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, input logic [DW-1:0] e, input string tag);
    raddr = a;
    #1;
    chk(rdata == e, tag, longint'(rdata), longint'(e));
  endtask

  task automatic do_frame(input bit keep, input logic [NUM_CS-1:0] exp_cs, input string tag);
    int lows;
    req = 1'b1;
    do @(negedge clk); while (!gnt);
    if (!keep) req = 1'b0;
    chk(cs == exp_cs, tag, longint'(cs), longint'(exp_cs));
    lows = 0;
    repeat (3) begin
      @(negedge clk);
      if (!gnt) lows++;
    end
    chk(lows == 0, "R11 grant held until done", longint'(lows), 0);
    done = 1'b1;
    @(negedge clk);
    done = 1'b0;
  endtask

  task automatic summary;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_run++;
      n_fail++;
      $display("FAIL R11 watchdog expired actual=hang expected=finish");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; we = 1'b0; waddr = '0; wdata = '0; raddr = '0;
    tick = 1'b1; req = 1'b0; done = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(A_ID,   32'h0,        "R1 index reset");
    rd(A_DEF,  32'hF,        "R1 idle levels reset");
    rd(A_MODE, 32'h0,        "R1 mode reset");
    rd(A_DLY0, 32'h0001_0001, "R1 delay word 0 reset");
    rd(A_DLY1, 32'h0000_0001, "R1 delay word 1 reset");
    chk(cs == 4'hF, "R1 lines idle", longint'(cs), 4'hF);
    chk(gnt == 1'b0, "R1 grant low", longint'(gnt), 0);

    // R2 line-count discovery, R3 idle levels
    wr(A_DEF, 32'hFFFF_FFFF);
    rd(A_DEF, 32'hF, "R2 masked read-back");
    wr(A_DEF, 32'hFFFF_FFFA);
    rd(A_DEF, 32'hA, "R2 partial pattern");
    chk(cs == 4'hA, "R3 idle lines follow levels", longint'(cs), 4'hA);
    wr(A_DEF, 32'hF);

    // R10 delay field layout
    wr(A_DLY0, 32'hFFFF_FFFF);
    rd(A_DLY0, 32'h00FF_00FF, "R10 delay word 0 fields");
    wr(A_DLY1, 32'hFFFF_FFFF);
    rd(A_DLY1, 32'h00FF_00FF, "R10 delay word 1 fields");

    // auto mode back-to-back: R4 R5 R6
    wr(A_DLY0, 32'h0002_0003);
    wr(A_DLY1, 32'h0000_0002);
    wr(A_ID, 32'd2);
    cur_def = 4'hF;
    repeat (2) @(negedge clk);
    mon_en = 1'b1;
    push(0, 3, "R4 lead of three");
    push(1, 2, "R5 lag of two");
    push(2, 3, "R6 rest of two plus idle cycle");
    push(0, 3, "R4 lead second frame");
    push(1, 2, "R5 lag second frame");
    do_frame(1'b1, 4'b1011, "R3 line 2 asserted low");
    track_rise = 1'b1;
    do_frame(1'b0, 4'b1011, "R3 line 2 second frame");
    track_rise = 1'b0;
    repeat (8) @(negedge clk);
    mon_en = 1'b0;

    // R3 active-high lines, minimal delays
    wr(A_DEF, 32'h5);
    cur_def = 4'h5;
    wr(A_ID, 32'd0);
    wr(A_DLY0, 32'h0001_0001);
    repeat (2) @(negedge clk);
    mon_en = 1'b1;
    push(0, 1, "R4 lead of one");
    push(1, 1, "R5 lag of one");
    do_frame(1'b0, 4'b0100, "R3 polarity inverted");
    repeat (6) @(negedge clk);
    mon_en = 1'b0;
    chk(cs == 4'h5, "R3 back to idle levels", longint'(cs), 4'h5);
    wr(A_DEF, 32'hF);
    cur_def = 4'hF;

    // R3 index beyond lines
    wr(A_ID, 32'd7);
    do_frame(1'b0, 4'hF, "R3 out-of-range index asserts none");
    repeat (6) @(negedge clk);

    // hold mode: R7, release R9
    wr(A_ID, 32'd1);
    wr(A_MODE, 32'd2);
    wr(A_DLY0, 32'h0002_0002);
    wr(A_DLY1, 32'h0003_0001);
    repeat (2) @(negedge clk);
    mon_en = 1'b1;
    push(0, 2, "R4 lead in hold mode");
    push(0, 6, "R7 held gap lag+1+gap");
    do_frame(1'b1, 4'b1101, "R3 line 1 asserted");
    do_frame(1'b0, 4'b1101, "R7 line stays for second frame");
    mon_en = 1'b0;
    repeat (10) @(negedge clk);
    chk(cs == 4'b1101, "R7 line held without request", longint'(cs), 4'b1101);
    wr(A_MODE, 32'd0);
    repeat (3) @(negedge clk);
    chk(cs == 4'hF, "R9 leaving hold releases line", longint'(cs), 4'hF);
    repeat (4) @(negedge clk);

    // R9 writes during a frame are deferred
    req = 1'b1;
    do @(negedge clk); while (!gnt);
    req = 1'b0;
    wr(A_ID, 32'd3);
    wr(A_MODE, 32'd3);
    @(negedge clk);
    chk(cs == 4'b1101, "R9 index write deferred", longint'(cs), 4'b1101);
    chk(gnt == 1'b1, "R11 grant held during writes", longint'(gnt), 1);
    done = 1'b1;
    @(negedge clk);
    done = 1'b0;
    repeat (8) @(negedge clk);
    rd(A_ID, 32'd3, "R9 index register updated");

    // R8 off mode
    req = 1'b1;
    @(negedge clk);
    chk(gnt == 1'b1, "R8 grant one cycle after request", longint'(gnt), 1);
    chk(cs == 4'hF, "R8 no line asserted", longint'(cs), 4'hF);
    req = 1'b0;
    repeat (2) @(negedge clk);
    done = 1'b1;
    @(negedge clk);
    done = 1'b0;
    chk(gnt == 1'b0, "R8 grant drops after done", longint'(gnt), 0);
    wr(A_MODE, 32'd0);
    do_frame(1'b0, 4'b0111, "R9 new index applied next frame");
    repeat (6) @(negedge clk);

    // R4 delays count ticks only
    wr(A_ID, 32'd0);
    wr(A_DLY0, 32'h0001_0002);
    tick = 1'b0;
    req = 1'b1;
    repeat (8) @(negedge clk);
    chk(gnt == 1'b0, "R4 no grant without ticks", longint'(gnt), 0);
    chk(cs == 4'b1110, "R4 line asserted while waiting", longint'(cs), 4'b1110);
    tick = 1'b1;
    @(negedge clk);
    chk(gnt == 1'b0, "R4 one tick not enough", longint'(gnt), 0);
    @(negedge clk);
    chk(gnt == 1'b1, "R4 grant on second tick", longint'(gnt), 1);
    req = 1'b0;
    done = 1'b1;
    @(negedge clk);
    done = 1'b0;
    repeat (6) @(negedge clk);

    chk(exp_q.size() == 0, "R4 all expected timing events seen",
        longint'(exp_q.size()), 0);

    finished = 1'b1;
    summary();
    $finish;
  end
endmodule